// File: doc/BRIEF.md
# USB Transfer Descriptor Status Updater

This block takes one transfer descriptor at a time, given as its control word and its token word, together with the outcome of the matching bus transaction: success with a byte count, NAK, stall, babble or timeout. It produces four things:

- the control word as it must be stored back;
- the fields decoded from the token;
- a two-bit interrupt-mask contribution;
- a verdict that tells the schedule walker what to do next: move on, treat the descriptor as unsuccessful, or stop the current frame.

It also raises a USB-error flag when the retry budget of a descriptor runs out. It raises a host-process-error flag when the token carries an unknown packet ID.

The schedule walker offers a descriptor with a valid/ready handshake. The result comes back one cycle after acceptance through a second valid/ready pair. The result is held until it is taken, and a new descriptor can be accepted in the same cycle as the old result leaves. A write-back flag tells the walker whether the control word changed, so that it can skip the memory write when it did not.

Top module: `td_status_update`

## Requirements
- R1: `in_ready` is high exactly when no result is held or `out_ready` is high. A descriptor accepted on a clock edge gives `out_valid` high after that edge. A held result stays unchanged while `out_ready` is low.
- R2: The token decodes into `out_pid` = bits 7:0, `out_addr` = bits 14:8 and `out_endp` = bits 18:15. `out_maxlen` = (bits 31:21 + 1) modulo 2048, so a field of 0x7FF gives a maximum length of 0.
- R3: If control bit 23 (active) is clear, the verdict is unsuccessful (1), the control word is returned unchanged, and no error flag is raised, whatever the outcome.
- R4: `out_imask` bit 0 equals control bit 24 (interrupt on complete) for every descriptor, active or not.
- R5: On an active descriptor whose packet ID is not SETUP (0x2D), IN (0x69) or OUT (0xE1), `out_hcperr` is set, the verdict is halt (2), and the control word is unchanged.
- R6: Outcome code 0 (success) writes (`in_len` - 1) modulo 2048 into control bits 10:0 and clears active. The verdict is continue (0) unless R7 applies.
- R7: A success for an IN packet with control bit 29 (short-packet detect) set and `in_len` below the maximum length gives verdict unsuccessful and sets `out_imask` bit 1.
- R8: Outcome code 3 (babble), and a successful IN whose `in_len` exceeds the maximum length, set control bits 20 and 22, clear active, and give verdict halt.
- R9: Outcome code 4 (timeout), and codes 5 to 7, set control bit 18. If the error count in bits 28:27 is nonzero, it is decremented. When the decrement reaches zero, active is cleared and `out_usberr` is set. The verdict is unsuccessful.
- R10: Outcome code 1 (NAK) sets control bit 19 and gives verdict unsuccessful with active kept. For a SETUP packet it sets bit 19 and is then handled as a timeout under R9.
- R11: Outcome code 2 (stall) sets control bit 22, clears active, and gives verdict unsuccessful.
- R12: `out_wb` is high exactly when `out_ctrl` differs from the control word that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be accepted |
| in_ctrl | input | 32 | Descriptor control word |
| in_token | input | 32 | Descriptor token word |
| in_kind | input | 3 | Outcome code (0 ok, 1 NAK, 2 stall, 3 babble, 4-7 timeout) |
| in_len | input | LEN_W | Bytes moved by the transaction |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result taken |
| out_ctrl | output | 32 | Updated control word |
| out_pid | output | 8 | Packet ID |
| out_addr | output | 7 | Device address |
| out_endp | output | 4 | Endpoint number |
| out_maxlen | output | 11 | Maximum length |
| out_imask | output | 2 | Interrupt mask contribution |
| out_verdict | output | 2 | 0 continue, 1 unsuccessful, 2 halt |
| out_usberr | output | 1 | Retry budget exhausted |
| out_hcperr | output | 1 | Unknown packet ID |
| out_wb | output | 1 | Control word changed |

## Verification
Random descriptors mix active and inactive control words, all three valid packet IDs plus unknown ones, every outcome code, and byte counts drawn below, at and above the maximum length. This separates the success, short-packet and babble branches, which differ only by how the count compares with the maximum. Directed cases pin the error-count edges: a count of 1 must exhaust the budget, while counts of 0 and 2 must not. They also cover a SETUP NAK, which must pick up both the NAK and the timeout updates, and a length field of 0x7FF, which wraps to a maximum of zero. A backpressure case holds the result while a second descriptor waits, which tells apart a correct hold from an early overwrite.

// File: rtl/td_status_update.sv
module td_status_update #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_ctrl,
  input  logic [31:0]      in_token,
  input  logic [2:0]       in_kind,
  input  logic [LEN_W-1:0] in_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_ctrl,
  output logic [7:0]       out_pid,
  output logic [6:0]       out_addr,
  output logic [3:0]       out_endp,
  output logic [10:0]      out_maxlen,
  output logic [1:0]       out_imask,
  output logic [1:0]       out_verdict,
  output logic             out_usberr,
  output logic             out_hcperr,
  output logic             out_wb
);
  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [1:0] V_CONT = 2'd0, V_UNSUCC = 2'd1, V_HALT = 2'd2;
  localparam int B_TMO = 18, B_NAK = 19, B_BAB = 20, B_STL = 22, B_ACT = 23;
  localparam int B_IOC = 24, B_SPD = 29;

  logic [7:0]  pid;
  logic [10:0] maxlen;
  logic        pid_ok, overlong, setup, is_in;
  logic [31:0] nctrl;
  logic [1:0]  nimask, nverd, err;
  logic        nusb, nhcp;
  logic        take;

  assign pid      = in_token[7:0];
  assign maxlen   = in_token[31:21] + 11'd1;
  assign setup    = pid == PID_SETUP;
  assign is_in    = pid == PID_IN;
  assign pid_ok   = setup || is_in || pid == PID_OUT;
  assign overlong = is_in && (in_len > LEN_W'(maxlen));
  assign err      = in_ctrl[28:27];
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    nctrl  = in_ctrl;
    nimask = {1'b0, in_ctrl[B_IOC]};
    nverd  = V_UNSUCC;
    nusb   = 1'b0;
    nhcp   = 1'b0;
    if (!in_ctrl[B_ACT]) begin
      nverd = V_UNSUCC;
    end else if (!pid_ok) begin
      nhcp  = 1'b1;
      nverd = V_HALT;
    end else if ((in_kind == 3'd0 && overlong) || in_kind == 3'd3) begin
      nctrl[B_BAB] = 1'b1;
      nctrl[B_STL] = 1'b1;
      nctrl[B_ACT] = 1'b0;
      nverd = V_HALT;
    end else if (in_kind == 3'd0) begin
      nctrl[10:0]  = 11'(in_len - LEN_W'(1));
      nctrl[B_ACT] = 1'b0;
      if (is_in && in_ctrl[B_SPD] && in_len < LEN_W'(maxlen)) begin
        nimask[1] = 1'b1;
        nverd = V_UNSUCC;
      end else begin
        nverd = V_CONT;
      end
    end else if (in_kind == 3'd2) begin
      nctrl[B_STL] = 1'b1;
      nctrl[B_ACT] = 1'b0;
    end else if (in_kind == 3'd1 && !setup) begin
      nctrl[B_NAK] = 1'b1;
    end else begin
      if (in_kind == 3'd1) nctrl[B_NAK] = 1'b1;
      nctrl[B_TMO] = 1'b1;
      if (err != 2'd0) begin
        nctrl[28:27] = err - 2'd1;
        if (err == 2'd1) begin
          nctrl[B_ACT] = 1'b0;
          nusb = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_ctrl    <= '0;
      out_pid     <= '0;
      out_addr    <= '0;
      out_endp    <= '0;
      out_maxlen  <= '0;
      out_imask   <= '0;
      out_verdict <= '0;
      out_usberr  <= 1'b0;
      out_hcperr  <= 1'b0;
      out_wb      <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_ctrl    <= nctrl;
      out_pid     <= pid;
      out_addr    <= in_token[14:8];
      out_endp    <= in_token[18:15];
      out_maxlen  <= maxlen;
      out_imask   <= nimask;
      out_verdict <= nverd;
      out_usberr  <= nusb;
      out_hcperr  <= nhcp;
      out_wb      <= nctrl != in_ctrl;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ctrl) && $stable(out_verdict));
  p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_verdict == V_HALT |->
      out_hcperr || (out_ctrl[B_BAB] && out_ctrl[B_STL] && !out_ctrl[B_ACT]));
  p_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_imask[1] |->
      out_verdict == V_UNSUCC && out_pid == PID_IN && out_ctrl[B_SPD] && !out_ctrl[B_ACT]);
  p_usberr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_usberr |->
      !out_ctrl[B_ACT] && out_ctrl[28:27] == 2'd0 && out_ctrl[B_TMO] && out_verdict == V_UNSUCC);
  p_cont_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_verdict == V_CONT |-> !out_ctrl[B_ACT] && out_wb && !out_hcperr);
  p_never3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_verdict != 2'd3);
endmodule

// File: tb/td_status_update_tb.sv
`timescale 1ns/1ps
module td_status_update_tb;
  localparam int LEN_W = 12;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic in_ready, out_valid;
  logic [31:0] in_ctrl = 0, in_token = 0;
  logic [2:0] in_kind = 0;
  logic [LEN_W-1:0] in_len = 0;
  logic [31:0] out_ctrl;
  logic [7:0] out_pid;
  logic [6:0] out_addr;
  logic [3:0] out_endp;
  logic [10:0] out_maxlen;
  logic [1:0] out_imask, out_verdict;
  logic out_usberr, out_hcperr, out_wb;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  td_status_update #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ctrl(in_ctrl), .in_token(in_token), .in_kind(in_kind), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_ctrl(out_ctrl),
    .out_pid(out_pid), .out_addr(out_addr), .out_endp(out_endp),
    .out_maxlen(out_maxlen), .out_imask(out_imask), .out_verdict(out_verdict),
    .out_usberr(out_usberr), .out_hcperr(out_hcperr), .out_wb(out_wb));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] c, input logic [31:0] t, input logic [2:0] k,
                       input logic [LEN_W-1:0] l, output logic [31:0] ec,
                       output logic [1:0] ei, output logic [1:0] ev,
                       output logic eu, output logic eh, output string tag);
    logic [7:0] p;
    int mx;
    p = t[7:0];
    mx = (int'(t[31:21]) + 1) % 2048;
    ec = c; ei = {1'b0, c[24]}; ev = 1; eu = 0; eh = 0;
    tag = "R3";
    if (c[23]) begin
      if (p != 8'h2D && p != 8'h69 && p != 8'hE1) begin
        eh = 1; ev = 2; tag = "R5";
      end else if (k == 3 || (k == 0 && p == 8'h69 && int'(l) > mx)) begin
        ec[20] = 1; ec[22] = 1; ec[23] = 0; ev = 2; tag = "R8";
      end else if (k == 0) begin
        ec[10:0] = 11'((int'(l) + 2047) % 2048); ec[23] = 0; ev = 0; tag = "R6";
        if (p == 8'h69 && c[29] && int'(l) < mx) begin ei[1] = 1; ev = 1; tag = "R7"; end
      end else if (k == 2) begin
        ec[22] = 1; ec[23] = 0; tag = "R11";
      end else if (k == 1 && p != 8'h2D) begin
        ec[19] = 1; tag = "R10";
      end else begin
        if (k == 1) ec[19] = 1;
        ec[18] = 1; tag = "R9";
        if (c[28:27] != 0) begin
          ec[28:27] = c[28:27] - 1;
          if (c[28:27] == 1) begin ec[23] = 0; eu = 1; end
        end
      end
    end
  endtask

  task automatic run(input logic [31:0] c, input logic [31:0] t, input logic [2:0] k,
                     input logic [LEN_W-1:0] l);
    logic [31:0] ec; logic [1:0] ei, ev; logic eu, eh; string tag;
    model(c, t, k, l, ec, ei, ev, eu, eh, tag);
    @(negedge clk);
    in_ctrl = c; in_token = t; in_kind = k; in_len = l; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk({"R1 valid ", tag}, 64'(out_valid), 64'd1);
    chk({tag, " ctrl"}, 64'(out_ctrl), 64'(ec));
    chk({"R4 imask ", tag}, 64'(out_imask), 64'(ei));
    chk({tag, " verdict"}, 64'(out_verdict), 64'(ev));
    chk({tag, " usberr"}, 64'(out_usberr), 64'(eu));
    chk({"R5 hcperr ", tag}, 64'(out_hcperr), 64'(eh));
    chk({"R12 wb ", tag}, 64'(out_wb), 64'(ec != c));
    chk({"R2 fields ", tag}, {out_pid, out_addr, out_endp, out_maxlen},
        {t[7:0], t[14:8], t[18:15], 11'(t[31:21] + 11'd1)});
  endtask

  function automatic logic [31:0] tok(input logic [10:0] mlf, input logic [7:0] p);
    return {mlf, 2'b01, 4'h5, 7'h3A, p};
  endfunction

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out_valid", 64'(out_valid), 64'd0);
    chk("R1 reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1;
    // R3 inactive with IOC set
    run(32'h0100_0000, tok(11'd7, 8'h69), 3'd4, 12'd3);
    // R5 unknown pid
    run(32'h0180_0000, tok(11'd7, 8'hA5), 3'd0, 12'd8);
    // R6 OUT success, zero length gives 0x7FF
    run(32'h0080_0000, tok(11'd7, 8'hE1), 3'd0, 12'd0);
    // R7 short IN with SPD
    run(32'h2080_0000, tok(11'd63, 8'h69), 3'd0, 12'd10);
    // R6 full IN with SPD
    run(32'h2080_0000, tok(11'd63, 8'h69), 3'd0, 12'd64);
    // R8 overlong IN
    run(32'h0080_0000, tok(11'd63, 8'h69), 3'd0, 12'd65);
    // R2 maxlen wrap: 0x7FF field -> 0, any data overlong
    run(32'h0080_0000, tok(11'h7FF, 8'h69), 3'd0, 12'd1);
    // R8 explicit babble
    run(32'h0880_0000, tok(11'd7, 8'hE1), 3'd3, 12'd0);
    // R9 timeout count edges 1, 2, 0
    run(32'h0880_0000, tok(11'd7, 8'h69), 3'd4, 12'd0);
    run(32'h1080_0000, tok(11'd7, 8'h69), 3'd4, 12'd0);
    run(32'h0080_0000, tok(11'd7, 8'h69), 3'd6, 12'd0);
    // R10 NAK on IN, NAK on SETUP
    run(32'h1880_0000, tok(11'd7, 8'h69), 3'd1, 12'd0);
    run(32'h0880_0000, tok(11'd7, 8'h2D), 3'd1, 12'd0);
    // R11 stall
    run(32'h0080_0000, tok(11'd7, 8'hE1), 3'd2, 12'd0);
    // R1 backpressure
    @(negedge clk);
    out_ready = 0;
    in_ctrl = 32'h0080_0000; in_token = tok(11'd7, 8'hE1); in_kind = 3'd2; in_valid = 1;
    @(posedge clk); @(negedge clk);
    in_ctrl = 32'h0080_0000; in_token = tok(11'd7, 8'hE1); in_kind = 3'd0; in_len = 12'd4;
    chk("R1 in_ready low while held", 64'(in_ready), 64'd0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 held ctrl", 64'(out_ctrl), 64'h0040_0000);
    chk("R1 held valid", 64'(out_valid), 64'd1);
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk("R1 next result", 64'(out_ctrl), 64'h0000_0003);
    @(posedge clk); @(negedge clk);
    chk("R1 drained", 64'(out_valid), 64'd0);
    // random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] c, t; logic [7:0] p; logic [10:0] mf; int r, lv;
      c = $urandom;
      c[23] = ($urandom % 5) != 0;
      r = $urandom % 10;
      p = (r < 3) ? 8'h69 : (r < 6) ? 8'hE1 : (r < 9) ? 8'h2D : 8'($urandom);
      mf = (($urandom % 8) == 0) ? 11'h7FF : 11'($urandom % 80);
      t = {mf, 21'($urandom)};
      t[7:0] = p;
      lv = int'(mf) + 1 + int'($urandom % 7) - 3;
      if (lv < 0) lv = 0;
      run(c, t, 3'($urandom), 12'(lv));
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule